// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM Port

This block is a synthesizable behavioural model of a synchronous burst SRAM access port, 32 bits wide and organised as four byte lanes. All address, data, strobe, select and write-control inputs are captured on the rising clock. Read data leaves through an output register together with a valid flag. The output enable and the sleep request act without reference to the clock edge.

A new access begins when one of two address strobes loads an external address. The processor-side strobe always opens a read. The controller-side strobe opens a read or a write, depending on the write controls. Three select inputs, looked at only when an address is loaded, decide whether the device is selected or deselected. Once a burst is open, the advance input steps a two-bit offset through a linear or an interleaved order. When advance is inactive, the same location is accessed again. A sleep request closes any open burst and makes the port ignore its inputs. Entry into sleep and recovery from it each take two clock edges.

Top module: `burst_sram_port`

## Requirements
- R1: An access sampled at clock edge k drives rdData and raises rdValid after edge k+1, and the output holds until the next edge.
- R2: procStrobeN low with primSelN low loads addrIn and starts a read, whatever the write controls are that cycle. procStrobeN low with primSelN high has no effect.
- R3: ctrlStrobeN low loads addrIn. The device is selected only if primSelN is low, auxSelHi is high and auxSelN is low; otherwise there is no access and advance cycles do nothing until the next selected load.
- R4: fullWrN low writes all four lanes. Otherwise, laneWrGateN low writes lane n (bits 8n+7:8n) for each laneWrN[n] that is low. A cycle that writes no lane is a read.
- R5: With no strobe active, advanceN low and a selected burst open, the access moves to the next burst address, and the write controls of that cycle decide read or write.
- R6: With no strobe active, advanceN high and a selected burst open, the access repeats at the current address.
- R7: The two low address bits follow (start + count) mod 4 when linearOrder is 1, and start XOR count when it is 0. The upper address bits stay as loaded.
- R8: A read issued on the cycle after a write to the same address returns the newly written data.
- R9: rdValid is low after a cycle with a write, a deselect or no access, until a read is again issued.
- R10: outEnN high forces rdValid low at once without changing the pipeline state. Lowering it again shows the held data.
- R11: A sleepReq high seen at edge e lets accesses at e and e+1 proceed, ignores inputs from e+2 on, and closes any open burst. After it falls before edge f, inputs are taken again from edge f+2.
- R12: If both strobes are low on one edge and primSelN is low, the processor-side strobe wins and the access is a read.
- R13: After reset rdValid is low and no burst is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low reset of the control and output registers |
| linearOrder | input | 1 | Burst order: 1 linear, 0 interleaved; held static |
| addrIn | input | ADDR_W | External word address |
| procStrobeN | input | 1 | Processor-side address strobe, active low |
| ctrlStrobeN | input | 1 | Controller-side address strobe, active low |
| advanceN | input | 1 | Burst advance, active low |
| primSelN | input | 1 | Primary select, active low |
| auxSelHi | input | 1 | Secondary select, active high |
| auxSelN | input | 1 | Secondary select, active low |
| fullWrN | input | 1 | Full-word write, active low |
| laneWrGateN | input | 1 | Gate for per-lane writes, active low |
| laneWrN | input | 4 | Per-lane write enables, active low, bit n for bits 8n+7:8n |
| wrData | input | 32 | Write data |
| outEnN | input | 1 | Output enable, active low, asynchronous |
| sleepReq | input | 1 | Sleep request, active high, asynchronous |
| rdData | output | 32 | Registered read data |
| rdValid | output | 1 | Read data valid |

## Verification
A write and a read to the same word can fall in consecutive edges, so their pipeline stages overlap. This is provoked by a per-lane write followed at once by a processor-strobe read of the same address. The result is judged by requiring the merged word, with only the enabled lanes changed, on the read output. The strobe-priority case is provoked by lowering both strobes together with an active full-word write. The bench judges it by reading that address back unchanged.

// File: rtl/sbr_pkg.sv
package sbr_pkg;
  localparam int LANE_W = 8;
  localparam int LANE_N = 4;
  localparam int DATA_W = LANE_W * LANE_N;
  localparam int OFS_W  = 2;

  typedef struct packed {
    logic              rd;
    logic              wr;
    logic [LANE_N-1:0] mask;
  } accStrb_t;
endpackage

// File: rtl/sbr_burst_seq.sv
module sbr_burst_seq
  import sbr_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             load,
  input  logic             step,
  input  logic             linearOrder,
  input  logic [OFS_W-1:0] startOfs,
  output logic [OFS_W-1:0] curOfs
);
  logic [OFS_W-1:0] baseQ;
  logic [OFS_W-1:0] cntQ;
  logic [OFS_W-1:0] cntNext;

  always_comb begin
    if (load)      cntNext = '0;
    else if (step) cntNext = cntQ + 1'b1;
    else           cntNext = cntQ;
  end

  always_comb begin
    if (linearOrder) curOfs = baseQ + cntNext;
    else             curOfs = baseQ ^ cntNext;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseQ <= '0;
      cntQ  <= '0;
    end else begin
      if (load) baseQ <= startOfs;
      cntQ <= cntNext;
    end
  end

  // R6
  hold_keeps_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!load && !step) |=> (cntQ == $past(cntQ)));
endmodule

// File: rtl/sbr_ctrl.sv
module sbr_ctrl
  import sbr_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int SNZ_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              linearOrder,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              procStrobeN,
  input  logic              ctrlStrobeN,
  input  logic              advanceN,
  input  logic              primSelN,
  input  logic              auxSelHi,
  input  logic              auxSelN,
  input  logic              fullWrN,
  input  logic              laneWrGateN,
  input  logic [LANE_N-1:0] laneWrN,
  input  logic              sleepReq,
  output accStrb_t          strbQ,
  output logic [ADDR_W-1:0] addrQ
);
  localparam int HI_W = ADDR_W - OFS_W;

  logic [SNZ_STAGES-1:0] snzPipe;
  logic                  inSleep;
  logic                  procGo;
  logic                  ctrlGo;
  logic                  loadNew;
  logic                  selOk;
  logic                  contGo;
  logic                  stepBurst;
  logic [LANE_N-1:0]     wrMask;
  logic                  burstActQ;
  logic [HI_W-1:0]       hiQ;
  logic [OFS_W-1:0]      curOfs;
  accStrb_t              strbNext;
  logic [ADDR_W-1:0]     addrNext;

  assign inSleep   = snzPipe[SNZ_STAGES-1];
  assign procGo    = !procStrobeN && !primSelN;
  assign ctrlGo    = !ctrlStrobeN;
  assign loadNew   = !inSleep && (procGo || ctrlGo);
  assign selOk     = !primSelN && auxSelHi && !auxSelN;
  assign contGo    = !inSleep && !loadNew && burstActQ;
  assign stepBurst = contGo && !advanceN;

  always_comb begin
    if (!fullWrN)          wrMask = '1;
    else if (!laneWrGateN) wrMask = ~laneWrN;
    else                   wrMask = '0;
  end

  sbr_burst_seq u_seq (
    .clk         (clk),
    .rstN        (rstN),
    .load        (loadNew),
    .step        (stepBurst),
    .linearOrder (linearOrder),
    .startOfs    (addrIn[OFS_W-1:0]),
    .curOfs      (curOfs)
  );

  always_comb begin
    strbNext = '0;
    addrNext = addrQ;
    if (loadNew && selOk) begin
      addrNext = addrIn;
      if (procGo) begin
        strbNext.rd = 1'b1;
      end else if (wrMask != '0) begin
        strbNext.wr   = 1'b1;
        strbNext.mask = wrMask;
      end else begin
        strbNext.rd = 1'b1;
      end
    end else if (contGo) begin
      addrNext = {hiQ, curOfs};
      if (wrMask != '0) begin
        strbNext.wr   = 1'b1;
        strbNext.mask = wrMask;
      end else begin
        strbNext.rd = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      snzPipe   <= '0;
      burstActQ <= 1'b0;
      hiQ       <= '0;
      strbQ     <= '0;
      addrQ     <= '0;
    end else begin
      snzPipe <= (snzPipe << 1) | SNZ_STAGES'(sleepReq);
      if (inSleep)      burstActQ <= 1'b0;
      else if (loadNew) burstActQ <= selOk;
      if (loadNew) hiQ <= addrIn[ADDR_W-1:OFS_W];
      strbQ <= strbNext;
      addrQ <= addrNext;
    end
  end

  // R2
  proc_start_reads_chk: assert property (@(posedge clk) disable iff (!rstN)
    (procGo && !inSleep) |=> !strbQ.wr);

  // R4
  full_write_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    (loadNew && !procGo && selOk && !fullWrN) |=> (strbQ.wr && strbQ.mask == '1));

  // R11
  sleep_blocks_access_chk: assert property (@(posedge clk) disable iff (!rstN)
    inSleep |=> (!strbQ.rd && !strbQ.wr));

  // R3
  deselect_no_access_chk: assert property (@(posedge clk) disable iff (!rstN)
    (loadNew && !selOk) |=> (!strbQ.rd && !strbQ.wr));
endmodule

// File: rtl/sbr_datapath.sv
module sbr_datapath
  import sbr_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  accStrb_t          strbQ,
  input  logic [ADDR_W-1:0] addrQ,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdDataQ,
  output logic              rdValidQ
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] dinQ;

  always_ff @(posedge clk) begin
    if (!rstN) dinQ <= '0;
    else       dinQ <= wrData;
  end

  for (genvar g = 0; g < LANE_N; g++) begin : g_lane
    logic [LANE_W-1:0] bank [DEPTH];
    logic [LANE_W-1:0] laneQ;

    always_ff @(posedge clk) begin
      if (strbQ.wr && strbQ.mask[g]) bank[addrQ] <= dinQ[g*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk) begin
      if (!rstN)         laneQ <= '0;
      else if (strbQ.rd) laneQ <= bank[addrQ];
    end

    assign rdDataQ[g*LANE_W +: LANE_W] = laneQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdValidQ <= 1'b0;
    else       rdValidQ <= strbQ.rd;
  end

  // R9
  write_clears_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    strbQ.wr |=> !rdValidQ);

  // R1
  read_sets_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    strbQ.rd |=> rdValidQ);
endmodule

// File: rtl/burst_sram_port.sv
module burst_sram_port
  import sbr_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int SNZ_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              linearOrder,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              procStrobeN,
  input  logic              ctrlStrobeN,
  input  logic              advanceN,
  input  logic              primSelN,
  input  logic              auxSelHi,
  input  logic              auxSelN,
  input  logic              fullWrN,
  input  logic              laneWrGateN,
  input  logic [LANE_N-1:0] laneWrN,
  input  logic [DATA_W-1:0] wrData,
  input  logic              outEnN,
  input  logic              sleepReq,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);
  accStrb_t          strbQ;
  logic [ADDR_W-1:0] addrQ;
  logic              rdValidQ;

  sbr_ctrl #(.ADDR_W(ADDR_W), .SNZ_STAGES(SNZ_STAGES)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .linearOrder (linearOrder),
    .addrIn      (addrIn),
    .procStrobeN (procStrobeN),
    .ctrlStrobeN (ctrlStrobeN),
    .advanceN    (advanceN),
    .primSelN    (primSelN),
    .auxSelHi    (auxSelHi),
    .auxSelN     (auxSelN),
    .fullWrN     (fullWrN),
    .laneWrGateN (laneWrGateN),
    .laneWrN     (laneWrN),
    .sleepReq    (sleepReq),
    .strbQ       (strbQ),
    .addrQ       (addrQ)
  );

  sbr_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strbQ    (strbQ),
    .addrQ    (addrQ),
    .wrData   (wrData),
    .rdDataQ  (rdData),
    .rdValidQ (rdValidQ)
  );

  assign rdValid = rdValidQ && !outEnN;
endmodule

// File: tb/burst_sram_port_bench.sv
module burst_sram_port_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic H = 1'b1;
  localparam logic L = 1'b0;

  typedef struct packed {
    logic        procN, ctrlN, advN, pselN, aselHi, aselN, fwN, gateN;
    logic [3:0]  laneN;
    logic [7:0]  addr;
    logic [31:0] din;
    logic        expV;
    logic [31:0] expD;
    logic [3:0]  reqNo;
  } vecT;

  localparam int NV = 22;
  localparam vecT VEC [NV] = '{
    '{H,L,H,L,H,L,L,H,4'hF,8'h10,32'h11111111,L,32'h0,4'd4},        // R4 full write
    '{H,H,L,L,H,L,L,H,4'hF,8'h00,32'h22222222,L,32'h0,4'd5},        // R5
    '{H,H,L,L,H,L,L,H,4'hF,8'h00,32'h33333333,L,32'h0,4'd5},        // R5
    '{H,H,L,L,H,L,L,H,4'hF,8'h00,32'h44444444,L,32'h0,4'd5},        // R5
    '{L,H,H,L,H,L,H,L,4'h0,8'h12,32'hFFFFFFFF,L,32'h0,4'd2},        // R2
    '{H,H,L,L,H,L,H,H,4'hF,8'h00,32'h0,H,32'h33333333,4'd1},        // R1
    '{H,H,L,L,H,L,H,H,4'hF,8'h00,32'h0,H,32'h44444444,4'd7},        // R7
    '{H,H,L,L,H,L,H,H,4'hF,8'h00,32'h0,H,32'h11111111,4'd7},        // R7 wrap
    '{H,H,H,L,H,L,H,H,4'hF,8'h00,32'h0,H,32'h22222222,4'd6},        // R6
    '{H,L,H,L,H,L,H,L,4'hA,8'h10,32'hAABBCCDD,H,32'h22222222,4'd6}, // R6 hold read
    '{L,H,H,L,H,L,H,H,4'hF,8'h10,32'h0,L,32'h0,4'd9},               // R9
    '{H,L,H,L,L,L,H,H,4'hF,8'h20,32'h0,H,32'h11BB11DD,4'd8},        // R8 lanes
    '{H,H,L,L,H,L,H,H,4'hF,8'h00,32'h0,L,32'h0,4'd3},               // R3
    '{H,L,H,L,H,L,H,H,4'hF,8'h13,32'h0,L,32'h0,4'd3},               // R3
    '{L,L,H,L,H,L,L,H,4'hF,8'h11,32'hDEADBEEF,H,32'h44444444,4'd4}, // R4 read
    '{H,L,H,L,H,H,H,H,4'hF,8'h30,32'h0,H,32'h22222222,4'd12},       // R12
    '{H,L,H,L,H,L,H,H,4'h0,8'h12,32'h0,L,32'h0,4'd3},               // R3
    '{H,H,H,L,H,L,H,H,4'hF,8'h00,32'h0,H,32'h33333333,4'd4},        // R4 gate high
    '{H,L,H,H,H,L,H,H,4'hF,8'h40,32'h0,H,32'h33333333,4'd6},        // R6
    '{H,H,H,L,H,L,H,H,4'hF,8'h00,32'h0,L,32'h0,4'd3},               // R3
    '{L,H,H,H,H,L,H,H,4'hF,8'h12,32'h0,L,32'h0,4'd3},               // R3
    '{H,H,H,L,H,L,H,H,4'hF,8'h00,32'h0,L,32'h0,4'd2}                // R2 ignored strobe
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        linearOrder = 1'b1;
  logic [7:0]  addrIn = '0;
  logic        procStrobeN = 1'b1, ctrlStrobeN = 1'b1, advanceN = 1'b1;
  logic        primSelN = 1'b0, auxSelHi = 1'b1, auxSelN = 1'b0;
  logic        fullWrN = 1'b1, laneWrGateN = 1'b1;
  logic [3:0]  laneWrN = 4'hF;
  logic [31:0] wrData = '0;
  logic        outEnN = 1'b0, sleepReq = 1'b0;
  logic [31:0] rdData;
  logic        rdValid;

  int nChk = 0;
  int nBad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_sram_port u_burst_sram_port (
    .clk(clk), .rstN(rstN), .linearOrder(linearOrder), .addrIn(addrIn),
    .procStrobeN(procStrobeN), .ctrlStrobeN(ctrlStrobeN), .advanceN(advanceN),
    .primSelN(primSelN), .auxSelHi(auxSelHi), .auxSelN(auxSelN),
    .fullWrN(fullWrN), .laneWrGateN(laneWrGateN), .laneWrN(laneWrN),
    .wrData(wrData), .outEnN(outEnN), .sleepReq(sleepReq),
    .rdData(rdData), .rdValid(rdValid)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drive(input vecT v);
    procStrobeN = v.procN; ctrlStrobeN = v.ctrlN; advanceN = v.advN;
    primSelN = v.pselN; auxSelHi = v.aselHi; auxSelN = v.aselN;
    fullWrN = v.fwN; laneWrGateN = v.gateN; laneWrN = v.laneN;
    addrIn = v.addr; wrData = v.din;
  endtask

  function automatic vecT mk(input logic p, input logic c, input logic a,
                             input logic s, input logic [7:0] ad);
    vecT v;
    v = '{H,H,H,L,H,L,H,H,4'hF,8'h00,32'h0,L,32'h0,4'd0};
    v.procN = p; v.ctrlN = c; v.advN = a; v.pselN = s; v.addr = ad;
    return v;
  endfunction

  task automatic chk(input string req, input logic expV, input logic [31:0] expD);
    nChk++;
    if (rdValid !== expV || (expV && rdData !== expD)) begin
      nBad++;
      $display("FAIL %s: valid=%0b data=%08h, expected valid=%0b data=%08h",
               req, rdValid, rdData, expV, expD);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  endtask

  initial begin
    repeat (4000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finishRun();
  end

  initial begin
    @(negedge clk);
    step();
    step();
    rstN = 1'b1;
    chk("R13 reset", L, 32'h0);
    step();
    chk("R13 idle after reset", L, 32'h0);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i]);
      step();
      chk($sformatf("R%0d vector %0d", VEC[i].reqNo, i), VEC[i].expV, VEC[i].expD);
    end

    // R7 interleaved order from start offset 1: 0x11, 0x10, 0x13, 0x12
    linearOrder = 1'b0;
    drive(mk(L, H, H, L, 8'h11)); step();
    drive(mk(H, H, L, L, 8'h00)); step(); chk("R7 interleave 0", H, 32'h22222222);
    drive(mk(H, H, L, L, 8'h00)); step(); chk("R7 interleave 1", H, 32'h11BB11DD);
    drive(mk(H, H, L, L, 8'h00)); step(); chk("R7 interleave 2", H, 32'h44444444);
    drive(mk(H, L, H, H, 8'h00)); step(); chk("R7 interleave 3", H, 32'h33333333);
    drive(mk(H, H, H, L, 8'h00)); step(); chk("R7 after deselect", L, 32'h0);
    linearOrder = 1'b1;

    // R10 output enable gating
    drive(mk(H, L, H, L, 8'h13)); step();
    drive(mk(H, H, H, L, 8'h00)); outEnN = 1'b1; step();
    chk("R10 disabled output", L, 32'h0);
    outEnN = 1'b0; #1;
    chk("R10 re-enabled output", H, 32'h44444444);
    drive(mk(H, L, H, H, 8'h00)); step();
    drive(mk(H, H, H, L, 8'h00)); step();
    chk("R10 idle", L, 32'h0);

    // R11 sleep entry and recovery
    sleepReq = 1'b1;
    drive(mk(H, L, H, L, 8'h13)); step();
    drive(mk(H, L, H, L, 8'h12)); step(); chk("R11 entry edge e", H, 32'h44444444);
    drive(mk(H, L, H, L, 8'h11)); step(); chk("R11 entry edge e+1", H, 32'h33333333);
    step(); chk("R11 ignored in sleep", L, 32'h0);
    step(); chk("R11 still ignored", L, 32'h0);
    sleepReq = 1'b0;
    drive(mk(H, L, H, L, 8'h10)); step();
    drive(mk(H, H, L, L, 8'h00)); step(); chk("R11 recovery edge f", L, 32'h0);
    step(); chk("R11 recovery edge f+1", L, 32'h0);
    drive(mk(H, L, H, L, 8'h13)); step(); chk("R11 burst closed by sleep", L, 32'h0);
    drive(mk(H, H, H, H, 8'h00)); step(); chk("R11 accepted after recovery", H, 32'h44444444);

    finishRun();
  end
endmodule